// File: doc/BRIEF.md
# Overscan Border Color Palette

This block is the color stage at the end of a video pipeline. It holds 256 palette entries, each made of 6-bit red, green and blue values, plus one extra entry for the border color. The extra entry is not one of the 256 normal entries. Each pixel clock the block takes a blank flag, an active-video flag and an 8-bit pixel index. It drives an 18-bit RGB word that is one of three things: black while blanked, the border color in the overscan band around the picture, or the palette color of the pixel inside the picture.

The host reaches the block through one small register port that selects one of four targets:

- the palette pointer;
- the palette data, written or read as three components in turn;
- a control byte with two meaningful bits;
- a border-index byte that names the normal entry used as the border color.

One control bit moves a single palette slot, index 2, over to the extra entry, so that the host can load that entry. The other control bit makes the overscan band use the extra entry instead of the entry named by the border-index byte.

Top module: `pal_border_palette`

## Requirements
- R1: After reset `rgb_out` is 0, and the control byte, the border-index byte and the palette pointer all read back as 0.
- R2: Three data writes (`host_sel`=1) load red, green and blue, in that order, into the entry at the pointer. After the blue write the pointer advances by one. Data reads return the entry's components in the same order, with the 6-bit value in bits 5:0 and 0 in bits 7:6. Data reads advance the pointer in the same way.
- R3: A pointer write (`host_sel`=0) sets the pointer and restarts the component sequence at red. A pointer read returns the current pointer.
- R4: While control bit 1 is 1, data accesses at index 2 read and write the extra border entry, and leave normal entry 2 untouched. Accesses at every other index reach the normal entries.
- R5: While control bit 1 is 0, data accesses at every index, index 2 included, reach the normal entries, and leave the extra entry untouched.
- R6: With blank low, active low and control bit 7 at 0, `rgb_out` is the normal entry selected by the border-index byte (`host_sel`=3).
- R7: With blank low, active low and control bit 7 at 1, `rgb_out` is the extra border entry.
- R8: With blank low and active high, `rgb_out` is the normal entry at `pix_index`.
- R9: With blank high, `rgb_out` is 0 whatever the other inputs and the control bits are.
- R10: Every output source has the same latency. The result for inputs sampled at clock edge k appears after edge k+1, so inputs that change every cycle give one result per cycle with no gap.

`rgb_out` carries red in bits 17:12, green in bits 11:6 and blue in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; it advances the data sequence |
| host_sel | input | 2 | Target: 0 pointer, 1 data, 2 control, 3 border index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected target |
| pix_blank | input | 1 | Blank interval flag |
| pix_active | input | 1 | Active-picture flag |
| pix_index | input | 8 | Pixel palette index |
| rgb_out | output | 18 | Color output {R,G,B} |

## Verification
A host write takes effect at the next clock edge, so the bench reads back at the following falling edge. Read data is combinational for the current pointer and component, and the bench samples it one time unit after it drives the strobe.

A pixel result is due two edges after the falling edge on which its inputs were driven. In single-vector tests the bench holds the inputs across two rising edges and samples at the falling edge that follows. In the streaming test it changes the inputs every cycle and compares each sample with the vector driven two falling edges earlier.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_BIDX = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    SRC_BLACK   = 2'd0,
    SRC_PIXEL   = 2'd1,
    SRC_BRD_STD = 2'd2,
    SRC_BRD_HID = 2'd3
  } src_e;

  // Source for a pixel: blanking wins, then the picture, then the border.
  function automatic src_e pick_src(input logic blank, input logic active,
                                    input logic use_hidden);
    if (blank)           return SRC_BLACK;
    else if (active)     return SRC_PIXEL;
    else if (use_hidden) return SRC_BRD_HID;
    else                 return SRC_BRD_STD;
  endfunction

  function automatic comp_e next_comp(input comp_e c);
    case (c)
      C_RED:   return C_GRN;
      C_GRN:   return C_BLU;
      default: return C_RED;
    endcase
  endfunction
endpackage

// File: rtl/pal_host_regs.sv
module pal_host_regs
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 6,
  parameter int HID_SLOT = 2,
  parameter int ACC_BIT  = 1,
  parameter int BEN_BIT  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  host_sel_e             host_sel,
  input  logic [BUS_W-1:0]      host_wdata,
  output logic [IDX_W-1:0]      ptr,
  output comp_e                 comp,
  output logic                  alt_access,
  output logic                  border_hid_en,
  output logic [IDX_W-1:0]      border_idx,
  output logic                  acc_hidden,
  output logic                  commit_normal,
  output logic                  commit_hidden,
  output logic [3*COMP_W-1:0]   commit_rgb
);
  logic [COMP_W-1:0] sh_r, sh_g;
  logic data_wr, data_rd, blue_wr;

  assign data_wr    = host_wr && (host_sel == SEL_DATA);
  assign data_rd    = !host_wr && host_rd && (host_sel == SEL_DATA);
  assign blue_wr    = data_wr && (comp == C_BLU);
  assign acc_hidden = alt_access && (ptr == IDX_W'(HID_SLOT));

  assign commit_hidden = blue_wr && acc_hidden;
  assign commit_normal = blue_wr && !acc_hidden;
  assign commit_rgb    = {sh_r, sh_g, host_wdata[COMP_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr           <= '0;
      comp          <= C_RED;
      alt_access    <= 1'b0;
      border_hid_en <= 1'b0;
      border_idx    <= '0;
      sh_r          <= '0;
      sh_g          <= '0;
    end else if (host_wr) begin
      case (host_sel)
        SEL_PTR: begin
          ptr  <= host_wdata[IDX_W-1:0];
          comp <= C_RED;
        end
        SEL_DATA: begin
          if (comp == C_RED) sh_r <= host_wdata[COMP_W-1:0];
          if (comp == C_GRN) sh_g <= host_wdata[COMP_W-1:0];
          if (comp == C_BLU) ptr  <= ptr + 1'b1;
          comp <= next_comp(comp);
        end
        SEL_CTRL: begin
          alt_access    <= host_wdata[ACC_BIT];
          border_hid_en <= host_wdata[BEN_BIT];
        end
        default: border_idx <= host_wdata[IDX_W-1:0];
      endcase
    end else if (data_rd) begin
      if (comp == C_BLU) ptr <= ptr + 1'b1;
      comp <= next_comp(comp);
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit_normal,
  input  logic                commit_hidden,
  input  logic [IDX_W-1:0]    commit_idx,
  input  logic [3*COMP_W-1:0] commit_rgb,
  input  logic [IDX_W-1:0]    host_ridx,
  input  logic                host_rhid,
  output logic [3*COMP_W-1:0] host_rgb,
  input  logic [IDX_W-1:0]    pix_ridx,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic [3*COMP_W-1:0] hid_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int RGB_W = 3 * COMP_W;

  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      hid_rgb <= '0;
    end else begin
      if (commit_normal) mem[commit_idx] <= commit_rgb;
      if (commit_hidden) hid_rgb <= commit_rgb;
    end
  end

  assign host_rgb = host_rhid ? hid_rgb : mem[host_ridx];
  assign pix_rgb  = mem[pix_ridx];
endmodule

// File: rtl/pal_pixel_pipe.sv
module pal_pixel_pipe
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pix_blank,
  input  logic                pix_active,
  input  logic [IDX_W-1:0]    pix_index,
  input  logic                border_hid_en,
  input  logic [IDX_W-1:0]    border_idx,
  output logic [IDX_W-1:0]    s1_ridx,
  input  logic [3*COMP_W-1:0] pal_rgb,
  input  logic [3*COMP_W-1:0] hid_rgb,
  output src_e                s1_src,
  output logic                s1_blank,
  output logic [3*COMP_W-1:0] rgb_out
);
  // Stage 1: pick the source and the palette slot to read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_src   <= SRC_BLACK;
      s1_blank <= 1'b1;
      s1_ridx  <= '0;
    end else begin
      s1_src   <= pick_src(pix_blank, pix_active, border_hid_en);
      s1_blank <= pix_blank;
      s1_ridx  <= pix_active ? pix_index : border_idx;
    end
  end

  // Stage 2: the same register for every source, so all sources have equal latency.
  always_ff @(posedge clk) begin
    if (!rst_n) rgb_out <= '0;
    else begin
      case (s1_src)
        SRC_BLACK:   rgb_out <= '0;
        SRC_BRD_HID: rgb_out <= hid_rgb;
        default:     rgb_out <= pal_rgb;
      endcase
    end
  end
endmodule

// File: rtl/pal_border_palette.sv
module pal_border_palette
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 6,
  parameter int HID_SLOT = 2,
  parameter int ACC_BIT  = 1,
  parameter int BEN_BIT  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [1:0]          host_sel,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  input  logic                pix_blank,
  input  logic                pix_active,
  input  logic [IDX_W-1:0]    pix_index,
  output logic [3*COMP_W-1:0] rgb_out
);
  localparam int RGB_W = 3 * COMP_W;

  host_sel_e        sel;
  logic [IDX_W-1:0] ptr, border_idx, s1_ridx;
  comp_e            comp;
  logic             alt_access, border_hid_en, acc_hidden;
  logic             commit_normal, commit_hidden, s1_blank;
  logic [RGB_W-1:0] commit_rgb, host_rgb, pix_rgb, hid_rgb;
  src_e             s1_src;
  logic [COMP_W-1:0] rd_comp;
  logic [BUS_W-1:0]  ctl_byte;

  assign sel = host_sel_e'(host_sel);

  pal_host_regs #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .HID_SLOT(HID_SLOT),
    .ACC_BIT(ACC_BIT), .BEN_BIT(BEN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(sel), .host_wdata(host_wdata), .ptr(ptr), .comp(comp),
    .alt_access(alt_access), .border_hid_en(border_hid_en),
    .border_idx(border_idx), .acc_hidden(acc_hidden),
    .commit_normal(commit_normal), .commit_hidden(commit_hidden),
    .commit_rgb(commit_rgb)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_normal(commit_normal),
    .commit_hidden(commit_hidden), .commit_idx(ptr), .commit_rgb(commit_rgb),
    .host_ridx(ptr), .host_rhid(acc_hidden), .host_rgb(host_rgb),
    .pix_ridx(s1_ridx), .pix_rgb(pix_rgb), .hid_rgb(hid_rgb)
  );

  pal_pixel_pipe #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pix_blank(pix_blank), .pix_active(pix_active),
    .pix_index(pix_index), .border_hid_en(border_hid_en),
    .border_idx(border_idx), .s1_ridx(s1_ridx), .pal_rgb(pix_rgb),
    .hid_rgb(hid_rgb), .s1_src(s1_src), .s1_blank(s1_blank), .rgb_out(rgb_out)
  );

  always_comb begin
    case (comp)
      C_RED:   rd_comp = host_rgb[RGB_W-1 -: COMP_W];
      C_GRN:   rd_comp = host_rgb[2*COMP_W-1 -: COMP_W];
      default: rd_comp = host_rgb[COMP_W-1:0];
    endcase
    ctl_byte = '0;
    ctl_byte[ACC_BIT] = alt_access;
    ctl_byte[BEN_BIT] = border_hid_en;
    case (sel)
      SEL_PTR:  host_rdata = BUS_W'(ptr);
      SEL_DATA: host_rdata = BUS_W'(rd_comp);
      SEL_CTRL: host_rdata = ctl_byte;
      default:  host_rdata = BUS_W'(border_idx);
    endcase
  end
endmodule

// File: rtl/pal_border_chk.sv
module pal_border_chk
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                s1_blank,
  input src_e                s1_src,
  input logic                commit_normal,
  input logic                commit_hidden,
  input logic [3*COMP_W-1:0] commit_rgb,
  input logic [3*COMP_W-1:0] hid_rgb,
  input logic [IDX_W-1:0]    ptr,
  input logic [3*COMP_W-1:0] rgb_out
);
  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_blank |=> (rgb_out == '0));

  // R4
  hidden_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hidden |=> (hid_rgb == $past(commit_rgb)));

  // R5
  hidden_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_normal |=> $stable(hid_rgb));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_normal || commit_hidden) |=> (ptr == $past(ptr) + 1'b1));

  // R7
  border_hid_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_src == SRC_BRD_HID) |=> (rgb_out == $past(hid_rgb)));
endmodule

bind pal_border_palette pal_border_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s1_blank(s1_blank), .s1_src(s1_src),
  .commit_normal(commit_normal), .commit_hidden(commit_hidden),
  .commit_rgb(commit_rgb), .hid_rgb(hid_rgb), .ptr(ptr), .rgb_out(rgb_out)
);

// File: tb/tb_pal_border_palette.sv
`timescale 1ns/1ps
module tb_pal_border_palette;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        pix_blank = 1'b1, pix_active = 1'b0;
  logic [7:0]  pix_index = 8'd0;
  logic [17:0] rgb_out;

  int checks = 0, errors = 0;
  logic [17:0] mdl [256];
  logic [17:0] mdl_hid = 18'd0;
  localparam logic [7:0]  BIDX = 8'd5;
  localparam logic [17:0] HID  = 18'h2D5A3;
  localparam logic [17:0] NEW2 = 18'h15C3A;

  always #10 clk = ~clk;

  pal_border_palette dut (.*);

  // {border_hid_en, blank, active, index}
  localparam logic [10:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b1, 8'h33}, {1'b1, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h33}, {1'b0, 1'b0, 1'b1, 8'h02},
    {1'b0, 1'b0, 1'b0, 8'h77}, {1'b1, 1'b0, 1'b0, 8'h77},
    {1'b1, 1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h40}, {1'b0, 1'b0, 1'b0, 8'h02}
  };

  function automatic logic [17:0] col(input logic [7:0] i);
    return {i[5:0], ~i[5:0], i[7:2]};
  endfunction

  function automatic logic [17:0] expect_rgb(input logic ben, input logic blank,
                                             input logic active, input logic [7:0] idx);
    if (blank) return 18'd0;
    if (active) return mdl[idx];
    return ben ? mdl_hid : mdl[BIDX];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] s, input logic [7:0] d);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] s, output logic [7:0] v);
    host_sel = s; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr_entry(input logic [17:0] c);
    hwr(2'd1, {2'b00, c[17:12]});
    hwr(2'd1, {2'b00, c[11:6]});
    hwr(2'd1, {2'b00, c[5:0]});
  endtask

  task automatic chk_entry(input string req, input logic [7:0] idx, input logic [17:0] e);
    logic [7:0] r, g, b;
    hwr(2'd0, idx);
    hrd(2'd1, r); hrd(2'd1, g); hrd(2'd1, b);
    chk(req, {r, g, b}, {2'b00, e[17:12], 2'b00, e[11:6], 2'b00, e[5:0]});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rgb", rgb_out, 18'd0);
    hrd(2'd2, v); chk("R1 ctrl", v, 8'd0);
    hrd(2'd3, v); chk("R1 bidx", v, 8'd0);
    hrd(2'd0, v); chk("R1 ptr", v, 8'd0);

    // R2 load all entries through auto-increment
    hwr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      mdl[i] = col(8'(i));
      wr_entry(mdl[i]);
    end
    hrd(2'd0, v); chk("R2 ptr wrap", v, 8'd0);
    chk_entry("R2 readback 10", 8'd10, mdl[10]);
    hrd(2'd0, v); chk("R2 ptr after read", v, 8'd11);

    // R3 pointer write restarts the sequence at red
    hwr(2'd0, 8'd20);
    hwr(2'd1, 8'h3F);
    hwr(2'd0, 8'd30);
    mdl[30] = 18'h0A5F1;
    wr_entry(mdl[30]);
    chk_entry("R3 restart", 8'd30, mdl[30]);
    chk_entry("R3 partial untouched", 8'd20, mdl[20]);

    hwr(2'd3, BIDX);
    hrd(2'd3, v); chk("R6 bidx reg", v, BIDX);

    // R4 hidden entry through slot 2
    hwr(2'd2, 8'h02);
    hrd(2'd2, v); chk("R4 ctrl readback", v, 8'h02);
    hwr(2'd0, 8'd2);
    wr_entry(HID);
    mdl_hid = HID;
    chk_entry("R4 hidden readback", 8'd2, HID);
    chk_entry("R4 other index normal", 8'd3, mdl[3]);
    hwr(2'd2, 8'h00);
    chk_entry("R4 normal 2 untouched", 8'd2, mdl[2]);

    // R5 slot 2 is normal while control bit 1 is 0
    hwr(2'd0, 8'd2);
    wr_entry(NEW2);
    mdl[2] = NEW2;
    chk_entry("R5 normal 2 written", 8'd2, NEW2);
    hwr(2'd2, 8'h02);
    chk_entry("R5 hidden untouched", 8'd2, HID);
    hwr(2'd2, 8'h00);

    // R6 R7 R8 R9 table walk
    foreach (VEC[k]) begin
      hwr(2'd2, VEC[k][10] ? 8'h80 : 8'h00);
      pix_blank = VEC[k][9]; pix_active = VEC[k][8]; pix_index = VEC[k][7:0];
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R6-table vec R7 R8 R9", rgb_out,
          expect_rgb(VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0]));
    end

    // R10 streaming: one result per cycle, two edges after the inputs
    hwr(2'd2, 8'h80);
    for (int i = 0; i < 12; i++) begin
      if (i >= 2) chk("R10 stream", rgb_out,
                      expect_rgb(1'b1, VEC[i-2][9], VEC[i-2][8], VEC[i-2][7:0]));
      if (i < 10) begin
        pix_blank = VEC[i][9]; pix_active = VEC[i][8]; pix_index = VEC[i][7:0];
      end
      @(negedge clk);
    end

    // R9 blank with every border setting
    hwr(2'd2, 8'h82);
    pix_blank = 1'b1; pix_active = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 blank overrides", rgb_out, 18'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule